// File: doc/BRIEF.md
# Packing Burst Write Master

This block moves a contiguous run of narrow values into an external memory whose data bus is several values wide. A client starts it with a first word address and a count of values. It then hands over the values one group of up to one bus word at a time through a valid/ready handshake. The block packs each group into a bus word, issues one write burst whose length is the number of bus words, and drives a byte-enable bit for every byte lane so that the final, partly filled word leaves the unused lanes of memory untouched.

The memory side uses a burst interface. The address and the burst length are presented with the first word and held for the whole burst. A write strobe marks a valid word, and a wait request from the memory freezes the current word until it drops. With a client that always has data ready and a memory that never stalls, one word is accepted on every clock. A single-cycle completion pulse follows the final accepted word. A start with a count of zero completes at once without any memory traffic.

Top module: `burst_pack_writer`

## Requirements
- R1: After reset, mem_write, busy, done and in_ready are all low.
- R2: A start taken while idle latches the word address and the value count. During the burst, mem_address carries that address and mem_burstcount carries ceil(count / LANES), both constant. Exactly that many words are accepted.
- R3: While mem_write and mem_waitreq are both high, the next cycle still has mem_write high with unchanged mem_wdata and mem_byteen.
- R4: With in_valid held high and mem_waitreq held low, accepted words follow one another on consecutive clocks with no bubble.
- R5: Values are packed little-endian. Value k of a group (bits k*VAL_W up of in_vals) lands in byte lanes starting at bit k*VAL_W of mem_wdata, and group g is written to word address start + g.
- R6: Every word except the last enables all byte lanes. The last word enables only the low (count mod LANES)*VAL_W/8 lanes when count is not a multiple of LANES. For example, a count of 5 on four 8-bit lanes gives a final mem_byteen of 4'b0001.
- R7: Lanes with a low enable carry zero data. Memory bytes outside the written values keep their prior contents, even when the client drives data on unused lanes.
- R8: done pulses high for one cycle on the clock after the final word is accepted, and busy is low in that cycle.
- R9: A start with count zero causes no mem_write and raises done on the next clock.
- R10: A start request while busy is ignored. The running burst keeps its address, length and data, and no memory outside it changes.
- R11: in_ready is high only while busy and while words remain to be taken from the client. The number of handshakes per burst equals the word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new burst (taken only when idle) |
| start_addr | input | ADDR_W | First bus-word address |
| val_count | input | CNT_W | Number of narrow values to write |
| in_valid | input | 1 | Client offers a group of values |
| in_vals | input | LANES*VAL_W | Group of values, value 0 in the low bits |
| in_ready | output | 1 | Block takes the offered group this cycle |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_write | output | 1 | Write strobe, a word is presented |
| mem_address | output | ADDR_W | Burst start word address |
| mem_burstcount | output | CNT_W | Burst length in bus words |
| mem_wdata | output | BUS_W | Packed write data |
| mem_byteen | output | BUS_W/8 | Per-byte-lane write enables |
| mem_waitreq | input | 1 | Memory stall, hold the current word |

## Verification
The bench targets value counts that leave one, two or three values in the last word, a single-value burst, and a count of zero. A block that got the tail wrong would enable too many lanes and overwrite neighbouring bytes in the byte-lane memory model, or write too few and leave values missing. Long and random wait-request stretches expose a word that changes or advances while stalled, which shows up as skipped or duplicated memory words. A second start fired mid-burst and junk on unused client lanes catch a block that restarts, retargets the address or leaks stray data into disabled lanes. A stall-free run with continuous data measures whether any bubble cycle appears between accepted words.

// File: rtl/bpw_pkg.sv
package bpw_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bpw_state_t;

  // number of bus words needed for a run of values (round up)
  function automatic int unsigned word_count(int unsigned vals, int unsigned lanes);
    return (vals + lanes - 1) / lanes;
  endfunction

  // number of values carried by the final bus word (1..lanes)
  function automatic int unsigned tail_fill(int unsigned vals, int unsigned lanes);
    return ((vals % lanes) == 0) ? lanes : (vals % lanes);
  endfunction

endpackage

// File: rtl/bpw_seq.sv
module bpw_seq import bpw_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int LANES  = 4,
  parameter int NV_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  val_count,
  input  logic              load,
  input  logic              accept,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  words_q,
  output logic              more_to_load,
  output logic [NV_W-1:0]   word_vals,
  output logic              final_accept
);

  bpw_state_t       state_q;
  logic [NV_W-1:0]  tail_q;
  logic [CNT_W-1:0] loaded_q;
  logic [CNT_W-1:0] acked_q;
  logic             done_q;
  logic             start_ok;
  logic             last_load;

  assign start_ok     = start && (state_q == ST_IDLE);
  assign busy         = (state_q == ST_RUN);
  assign more_to_load = busy && (loaded_q != words_q);
  assign last_load    = (loaded_q == words_q - CNT_W'(1));
  assign word_vals    = last_load ? tail_q : NV_W'(LANES);
  assign final_accept = accept && (acked_q == words_q - CNT_W'(1));
  assign done         = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      words_q  <= '0;
      tail_q   <= '0;
      loaded_q <= '0;
      acked_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        addr_q   <= start_addr;
        words_q  <= CNT_W'(word_count(32'(val_count), LANES));
        tail_q   <= NV_W'(tail_fill(32'(val_count), LANES));
        loaded_q <= '0;
        acked_q  <= '0;
        if (val_count == '0) begin
          done_q <= 1'b1;
        end else begin
          state_q <= ST_RUN;
        end
      end else if (busy) begin
        if (load) begin
          loaded_q <= loaded_q + CNT_W'(1);
        end
        if (final_accept) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else if (accept) begin
          acked_q <= acked_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/bpw_lane_pack.sv
module bpw_lane_pack #(
  parameter int VAL_W = 8,
  parameter int LANES = 4,
  parameter int NV_W  = 3
) (
  input  logic [LANES*VAL_W-1:0]     vals,
  input  logic [NV_W-1:0]            n_vals,
  output logic [LANES*VAL_W-1:0]     word,
  output logic [LANES*VAL_W/8-1:0]   byteen
);

  localparam int BPV = VAL_W / 8;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [NV_W-1:0] LIDX = NV_W'(l);
    logic lane_on;
    assign lane_on = (LIDX < n_vals);
    assign word[l*VAL_W +: VAL_W] = lane_on ? vals[l*VAL_W +: VAL_W] : '0;
    assign byteen[l*BPV +: BPV]   = {BPV{lane_on}};
  end

endmodule

// File: rtl/burst_pack_writer.sv
module burst_pack_writer #(
  parameter int VAL_W  = 8,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic [CNT_W-1:0]     val_count,
  input  logic                 in_valid,
  input  logic [BUS_W-1:0]     in_vals,
  output logic                 in_ready,
  output logic                 busy,
  output logic                 done,
  output logic                 mem_write,
  output logic [ADDR_W-1:0]    mem_address,
  output logic [CNT_W-1:0]     mem_burstcount,
  output logic [BUS_W-1:0]     mem_wdata,
  output logic [BUS_W/8-1:0]   mem_byteen,
  input  logic                 mem_waitreq
);

  localparam int LANES = BUS_W / VAL_W;
  localparam int BE_W  = BUS_W / 8;
  localparam int NV_W  = $clog2(LANES + 1);

  // named internal events
  logic              accept;
  logic              load;
  logic              final_accept;
  logic              more_to_load;
  logic [NV_W-1:0]   word_vals;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  words_q;
  logic [BUS_W-1:0]  pk_data;
  logic [BE_W-1:0]   pk_be;

  logic              wvalid_q;
  logic [BUS_W-1:0]  wdata_q;
  logic [BE_W-1:0]   wbe_q;

  assign accept   = wvalid_q && !mem_waitreq;
  assign in_ready = more_to_load && (!wvalid_q || !mem_waitreq);
  assign load     = in_valid && in_ready;

  bpw_seq #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .LANES  (LANES),
    .NV_W   (NV_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_addr   (start_addr),
    .val_count    (val_count),
    .load         (load),
    .accept       (accept),
    .busy         (busy),
    .done         (done),
    .addr_q       (addr_q),
    .words_q      (words_q),
    .more_to_load (more_to_load),
    .word_vals    (word_vals),
    .final_accept (final_accept)
  );

  bpw_lane_pack #(
    .VAL_W (VAL_W),
    .LANES (LANES),
    .NV_W  (NV_W)
  ) u_pack (
    .vals   (in_vals),
    .n_vals (word_vals),
    .word   (pk_data),
    .byteen (pk_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wvalid_q <= 1'b0;
      wdata_q  <= '0;
      wbe_q    <= '0;
    end else if (load) begin
      wvalid_q <= 1'b1;
      wdata_q  <= pk_data;
      wbe_q    <= pk_be;
    end else if (accept) begin
      wvalid_q <= 1'b0;
    end
  end

  assign mem_write      = wvalid_q;
  assign mem_address    = addr_q;
  assign mem_burstcount = words_q;
  assign mem_wdata      = wdata_q;
  assign mem_byteen     = wbe_q;

endmodule

// File: rtl/bpw_checks.sv
module bpw_checks #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int BUS_W  = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_write,
  input logic              mem_waitreq,
  input logic [BUS_W-1:0]  mem_wdata,
  input logic [BE_W-1:0]   mem_byteen,
  input logic [ADDR_W-1:0] mem_address,
  input logic [CNT_W-1:0]  mem_burstcount,
  input logic              busy,
  input logic              done,
  input logic              in_ready,
  input logic              accept,
  input logic              final_accept
);

  logic [CNT_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else if (final_accept) beat_q <= '0;
    else if (accept) beat_q <= beat_q + CNT_W'(1);
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_write && mem_waitreq) |=> (mem_write && $stable(mem_wdata) && $stable(mem_byteen)));

  assert_fixed_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(mem_address) && $stable(mem_burstcount))));

  assert_beat_total_R2: assert property (@(posedge clk) disable iff (!rst_n)
    final_accept |-> (beat_q + CNT_W'(1) == mem_burstcount));

  assert_some_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write |-> (mem_byteen != '0));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_write && !in_ready));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    final_accept |=> (done && !busy));

endmodule

bind burst_pack_writer bpw_checks #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .BUS_W  (BUS_W),
  .BE_W   (BUS_W/8)
) u_checks (
  .clk            (clk),
  .rst_n          (rst_n),
  .mem_write      (mem_write),
  .mem_waitreq    (mem_waitreq),
  .mem_wdata      (mem_wdata),
  .mem_byteen     (mem_byteen),
  .mem_address    (mem_address),
  .mem_burstcount (mem_burstcount),
  .busy           (busy),
  .done           (done),
  .in_ready       (in_ready),
  .accept         (accept),
  .final_accept   (final_accept)
);

// File: tb/burst_pack_writer_test.sv
`timescale 1ns/1ps
module burst_pack_writer_test;

  localparam int VAL_W  = 8;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 12;
  localparam int LANES  = BUS_W / VAL_W;
  localparam int BE_W   = BUS_W / 8;
  localparam int NWORDS = 64;

  // {addr, count, wait mode, flags}; flags bit0 = client gaps, bit1 = extra start mid-burst
  localparam logic [31:0] VECS [0:5] = '{
    {8'd2,  8'd8,  8'd0, 8'd0},
    {8'd10, 8'd5,  8'd1, 8'd0},
    {8'd20, 8'd7,  8'd1, 8'd1},
    {8'd30, 8'd6,  8'd2, 8'd2},
    {8'd40, 8'd16, 8'd1, 8'd1},
    {8'd50, 8'd1,  8'd0, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [CNT_W-1:0]  val_count = '0;
  logic in_valid = 1'b0;
  logic [BUS_W-1:0] in_vals = '0;
  logic in_ready, busy, done, mem_write;
  logic [ADDR_W-1:0] mem_address;
  logic [CNT_W-1:0]  mem_burstcount;
  logic [BUS_W-1:0]  mem_wdata;
  logic [BE_W-1:0]   mem_byteen;
  logic mem_waitreq = 1'b0;

  always #2.5 clk = ~clk;

  burst_pack_writer #(
    .VAL_W(VAL_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .val_count(val_count), .in_valid(in_valid), .in_vals(in_vals),
    .in_ready(in_ready), .busy(busy), .done(done), .mem_write(mem_write),
    .mem_address(mem_address), .mem_burstcount(mem_burstcount),
    .mem_wdata(mem_wdata), .mem_byteen(mem_byteen), .mem_waitreq(mem_waitreq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and expectation
  logic [7:0] mem [0:NWORDS*BE_W-1];
  logic [7:0] expm [0:NWORDS*BE_W-1];

  // per-burst expectations and monitor results
  int exp_words = 0;
  int exp_tail = LANES;
  int exp_addr = 0;
  int beats = 0;
  int hs_cnt = 0;
  int done_cnt = 0;
  int cyc = 0;
  int first_cyc = -1;
  int last_cyc = -1;
  int writes_seen = 0;
  bit busy_at_done = 0;
  bit prev_stall = 0;
  logic [BUS_W-1:0] prev_data = '0;
  logic [BE_W-1:0]  prev_be = '0;

  // wait request generator
  int wait_mode = 0;
  int hold_ctr = 0;
  logic [7:0] lfsr = 8'hA5;

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (wait_mode)
      1: mem_waitreq = lfsr[0] & lfsr[2];
      2: begin mem_waitreq = (hold_ctr < 8); hold_ctr++; end
      default: mem_waitreq = 1'b0;
    endcase
  end

  // memory-side monitor, samples 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    cyc++;
    if (rst_n) begin
      if (prev_stall) begin
        check(mem_write && mem_wdata == prev_data && mem_byteen == prev_be,
              "R3 stalled word held", longint'(mem_wdata), longint'(prev_data));
      end
      prev_stall = mem_write && mem_waitreq;
      prev_data = mem_wdata;
      prev_be = mem_byteen;
      if (in_valid && in_ready) hs_cnt++;
      if (mem_write) writes_seen++;
      if (mem_write && !mem_waitreq) begin
        logic [BE_W-1:0] ebe;
        ebe = (beats == exp_words - 1 && exp_tail != LANES) ? BE_W'((1 << exp_tail) - 1) : '1;
        check(mem_byteen == ebe, "R6 byte enables", longint'(mem_byteen), longint'(ebe));
        check(int'(mem_address) == exp_addr && int'(mem_burstcount) == exp_words,
              "R2 address and length", longint'(mem_address), longint'(exp_addr));
        for (int l = 0; l < BE_W; l++) begin
          if (mem_byteen[l]) mem[((int'(mem_address) + beats) % NWORDS) * BE_W + l] = mem_wdata[l*8 +: 8];
          else if (mem_wdata[l*8 +: 8] != 8'h00)
            check(1'b0, "R7 disabled lane data zero", longint'(mem_wdata[l*8 +: 8]), 0);
        end
        if (first_cyc < 0) first_cyc = cyc;
        last_cyc = cyc;
        beats++;
      end
      if (done) begin
        done_cnt++;
        busy_at_done = busy;
      end
    end
  end

  function automatic logic [7:0] val_of(int seed, int n);
    return 8'((n * 29 + seed * 13 + 1) & 255);
  endfunction

  task automatic prep(input int seed);
    for (int i = 0; i < NWORDS * BE_W; i++) begin
      mem[i] = 8'((i * 37 + 5 + seed) & 255);
      expm[i] = mem[i];
    end
    beats = 0; hs_cnt = 0; done_cnt = 0; first_cyc = -1; last_cyc = -1;
    writes_seen = 0; prev_stall = 0; hold_ctr = 0;
  endtask

  task automatic run_burst(input int addr, input int count, input int wmode, input int flags, input int seed);
    int g;
    @(negedge clk);
    prep(seed);
    exp_words = (count + LANES - 1) / LANES;
    exp_tail = (count % LANES == 0) ? LANES : count % LANES;
    exp_addr = addr;
    wait_mode = wmode;
    for (int n = 0; n < count; n++) expm[(addr + n / LANES) * BE_W + (n % LANES)] = val_of(seed, n);
    start = 1'b1; start_addr = ADDR_W'(addr); val_count = CNT_W'(count);
    @(negedge clk);
    start = 1'b0;
    g = 0;
    while (g < exp_words) begin
      if (cyc > 150000) break;
      start = (flags[1] && g == 1);
      start_addr = '0; val_count = CNT_W'(3);
      in_valid = !(flags[0] && (cyc % 2 == 1));
      for (int l = 0; l < LANES; l++) begin
        int n;
        n = g * LANES + l;
        in_vals[l*VAL_W +: VAL_W] = (n < count) ? val_of(seed, n) : 8'hEE;
      end
      #1.5;
      if (in_valid && in_ready) g++;
      @(negedge clk);
    end
    start = 1'b0; in_valid = 1'b0;
    for (int t = 0; t < 300 && done_cnt == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    wait_mode = 0;
    check(beats == exp_words, "R2 accepted word count", beats, exp_words);
    check(hs_cnt == exp_words, "R11 handshakes per burst", hs_cnt, exp_words);
    check(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
    check(!busy_at_done, "R8 busy low with done", busy_at_done, 0);
    check(!in_ready && !busy, "R11 idle after burst", in_ready, 0);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < NWORDS * BE_W; i++) if (mem[i] !== expm[i]) bad++;
      check(bad == 0, flags[1] ? "R10 memory after ignored start" : "R5 R7 memory image", bad, 0);
    end
    if (wmode == 0 && flags[0] == 0)
      check(last_cyc - first_cyc == exp_words - 1, "R4 back-to-back words", last_cyc - first_cyc, exp_words - 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!mem_write && !busy && !done && !in_ready, "R1 outputs during reset",
          {mem_write, busy, done, in_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!mem_write && !busy && !done && !in_ready, "R1 outputs after reset",
          {mem_write, busy, done, in_ready}, 0);
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      run_burst(int'(VECS[v][31:24]), int'(VECS[v][23:16]), int'(VECS[v][15:8]),
                int'(VECS[v][7:0]), v + 1);
    end

    // R9: zero-length request
    @(negedge clk);
    prep(9);
    start = 1'b1; start_addr = ADDR_W'(5); val_count = '0;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(done == 1'b1, "R9 done on next clock", done, 1);
    repeat (4) @(negedge clk);
    check(writes_seen == 0, "R9 no memory write", writes_seen, 0);
    check(done_cnt == 1, "R9 single done pulse", done_cnt, 1);

    // R6: longer burst with tail of two, random stalls
    run_burst(3, 26, 1, 0, 11);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule